// File: doc/BRIEF.md
# Indexed Configuration Address/Data Port Bridge

This block sits on a host I/O bus and gives indirect access to configuration space through two dword ports. One is a latched address register at I/O port 0xCF8. The other is a data window at port 0xCFC. Software loads the address register with an enable bit and a bus, device, function and register tuple. It then reads or writes the data window. The bridge turns each enabled data-window access into one configuration request on a simple downstream request/response interface. It returns the outcome to the host.

The address register can be read back, so software can probe for the bridge. Only a full-dword write changes the register, and only the implemented fields are kept. The host access stalls until the downstream target answers. If the target reports that it is absent, or stays silent for a parameterised number of cycles, the access completes with all ones. While the enable bit is clear, the data window does not reach downstream.

Top module: `cfg_port_bridge`

## Requirements
- R1: A host write with all four byte enables (io_be = 4'b1111) to the dword at port 0xCF8 loads the address register with the written value ANDed with 0x80FFFFFC. A read of that port returns the stored value, so 0x80000000 reads back unchanged.
- R2: After a full write of 0xFF000001 the address port reads 0x80000000. After a full write of 0x7F032A17 it reads 0x00032A14. Bits 30:24 and 1:0 always read zero.
- R3: A write to port 0xCF8 with any byte-enable pattern other than 4'b1111 leaves the address register unchanged. This includes a single-byte write to 0xCFB (io_be = 4'b1000).
- R4: With bit 31 set, an access to port 0xCFC issues exactly one downstream request. The request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword register index = bits 7:2 of the address register. A write request also carries the host write data and byte enables, with dn_req_write = 1.
- R5: An enabled data-port read completes with the data returned by the target.
- R6: A response with dn_rsp_absent = 1 completes the host read with 0xFFFFFFFF, whatever data accompanies it.
- R7: With bit 31 clear, no downstream request is made. A data-port read then returns 0xFFFFFFFF and a data-port write is dropped.
- R8: dn_req_valid, once raised, stays high with unchanged fields until dn_req_ready is seen, unless the timeout ends the access.
- R9: If no response arrives within TMO_CYCLES cycles of the access being accepted, the access completes with 0xFFFFFFFF. io_done is seen TMO_CYCLES+1 rising edges after the host raises io_valid.
- R10: A synchronous active-high reset clears the address register to 0.
- R11: Every accepted host access ends with io_done high for exactly one cycle. The host lowers io_valid after seeing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host access request, held until io_done |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address; bits 15:2 select the dword |
| io_be | input | 4 | Byte enables within the dword |
| io_wdata | input | 32 | Host write data |
| io_done | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read result, valid with io_done |
| dn_req_valid | output | 1 | Downstream configuration request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_write | output | 1 | Request is a configuration write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_func | output | 3 | Target function number |
| dn_reg | output | 6 | Dword register index |
| dn_wdata | output | 32 | Configuration write data |
| dn_be | output | 4 | Configuration write byte enables |
| dn_rsp_valid | input | 1 | Response strobe from downstream |
| dn_rsp_data | input | 32 | Response read data |
| dn_rsp_absent | input | 1 | Target not present |

## Verification
The bench builds the bridge with TMO_CYCLES = 8 and the default port addresses, so the silent-target case ends after a few cycles. The exact completion latency is therefore checked against a short, known window. The bench's target model answers only for device numbers below 8 and flags the rest as absent. That puts both the present and the absent path within reach of one address sweep. The model can also hold dn_req_ready low, or never respond, which exposes the request-hold and timeout paths.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} seq_st_t;

  localparam logic [31:0] KEEP_MASK = 32'h80FF_FFFC;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  // bits of the address register that survive a full write
  function automatic logic [31:0] addr_keep(input logic [31:0] w);
    return w & KEEP_MASK;
  endfunction

  // dword-granular match of a host port against a base port
  function automatic logic port_hit(input logic [15:0] port, input logic [15:0] base);
    return port[15:2] == base[15:2];
  endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] wdata,
  output logic [31:0] q,
  output logic        en,
  output logic [7:0]  bus,
  output logic [4:0]  dev,
  output logic [2:0]  func,
  output logic [5:0]  regidx
);
  logic [31:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= addr_keep(wdata);
  end

  assign q      = q_r;
  assign en     = q_r[31];
  assign bus    = q_r[23:16];
  assign dev    = q_r[15:11];
  assign func   = q_r[10:8];
  assign regidx = q_r[7:2];
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int TMO_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_fwd,
  input  logic        start_local,
  input  logic [31:0] local_data,
  input  logic        req_ready,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  input  logic        rsp_absent,
  output logic        idle,
  output logic        req_valid,
  output logic        done,
  output logic [31:0] rdata,
  output logic        tmo_hit
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TMO_CYCLES - 1);

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic [31:0]   rdata_r;
  logic          busy;
  logic          rsp_take;

  assign busy     = (st == ST_REQ) || (st == ST_WAIT);
  assign rsp_take = (st == ST_WAIT) && rsp_valid;
  assign tmo_hit  = busy && (tmr == TMR_LAST) && !rsp_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      rdata_r <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          tmr <= '0;
          if (start_fwd) st <= ST_REQ;
          else if (start_local) begin
            st      <= ST_DONE;
            rdata_r <= local_data;
          end
        end
        ST_REQ: begin
          tmr <= tmr + 1'b1;
          if (tmo_hit) begin
            st      <= ST_DONE;
            rdata_r <= ALL_ONES;
          end else if (req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          tmr <= tmr + 1'b1;
          if (rsp_take) begin
            st      <= ST_DONE;
            rdata_r <= rsp_absent ? ALL_ONES : rsp_data;
          end else if (tmo_hit) begin
            st      <= ST_DONE;
            rdata_r <= ALL_ONES;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign req_valid = (st == ST_REQ);
  assign done      = (st == ST_DONE);
  assign rdata     = rdata_r;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          TMO_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [15:0] io_port,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic        io_done,
  output logic [31:0] io_rdata,
  output logic        dn_req_valid,
  input  logic        dn_req_ready,
  output logic        dn_req_write,
  output logic [7:0]  dn_bus,
  output logic [4:0]  dn_dev,
  output logic [2:0]  dn_func,
  output logic [5:0]  dn_reg,
  output logic [31:0] dn_wdata,
  output logic [3:0]  dn_be,
  input  logic        dn_rsp_valid,
  input  logic [31:0] dn_rsp_data,
  input  logic        dn_rsp_absent
);
  logic        seq_idle;
  logic        accept;
  logic        hit_addr;
  logic        hit_data;
  logic        addr_load;
  logic        start_fwd;
  logic        start_local;
  logic [31:0] local_data;
  logic [31:0] addr_q;
  logic        addr_en;
  logic        tmo_hit;
  logic        wr_q;
  logic [31:0] wdata_q;
  logic [3:0]  be_q;

  assign hit_addr    = port_hit(io_port, ADDR_PORT);
  assign hit_data    = port_hit(io_port, DATA_PORT);
  assign accept      = io_valid && seq_idle && (hit_addr || hit_data);
  assign addr_load   = accept && hit_addr && io_write && (io_be == 4'hF);
  assign start_fwd   = accept && hit_data && addr_en;
  assign start_local = accept && !start_fwd;
  assign local_data  = hit_addr ? addr_q : ALL_ONES;

  cfgb_addr_reg u_areg (
    .clk    (clk),
    .rst    (rst),
    .load   (addr_load),
    .wdata  (io_wdata),
    .q      (addr_q),
    .en     (addr_en),
    .bus    (dn_bus),
    .dev    (dn_dev),
    .func   (dn_func),
    .regidx (dn_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start_fwd) begin
      wr_q    <= io_write;
      wdata_q <= io_wdata;
      be_q    <= io_be;
    end
  end

  assign dn_req_write = wr_q;
  assign dn_wdata     = wdata_q;
  assign dn_be        = be_q;

  cfgb_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_fwd   (start_fwd),
    .start_local (start_local),
    .local_data  (local_data),
    .req_ready   (dn_req_ready),
    .rsp_valid   (dn_rsp_valid),
    .rsp_data    (dn_rsp_data),
    .rsp_absent  (dn_rsp_absent),
    .idle        (seq_idle),
    .req_valid   (dn_req_valid),
    .done        (io_done),
    .rdata       (io_rdata),
    .tmo_hit     (tmo_hit)
  );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
  input logic        clk,
  input logic        rst,
  input logic        io_done,
  input logic [31:0] io_rdata,
  input logic        dn_req_valid,
  input logic        dn_req_ready,
  input logic [7:0]  dn_bus,
  input logic [4:0]  dn_dev,
  input logic [2:0]  dn_func,
  input logic [5:0]  dn_reg,
  input logic        addr_en,
  input logic        tmo_hit,
  input logic [31:0] addr_q
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && !dn_req_ready && !tmo_hit |=> dn_req_valid && $stable(dn_bus)
      && $stable(dn_dev) && $stable(dn_func) && $stable(dn_reg));

  assert_no_req_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> addr_en);

  assert_timeout_ones_R9: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> io_done && (io_rdata == 32'hFFFF_FFFF));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    io_done |=> !io_done);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (addr_q == 32'h0));
endmodule

bind cfg_port_bridge cfgb_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_done      (io_done),
  .io_rdata     (io_rdata),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_bus       (dn_bus),
  .dn_dev       (dn_dev),
  .dn_func      (dn_func),
  .dn_reg       (dn_reg),
  .addr_en      (addr_en),
  .tmo_hit      (tmo_hit),
  .addr_q       (addr_q)
);

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 8;
  localparam int N_PRESENT  = 8;
  localparam logic [15:0] PA = 16'h0CF8;
  localparam logic [15:0] PD = 16'h0CFC;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  function automatic logic [31:0] mk_addr(input logic en, input logic [7:0] b,
      input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
    return {en, 7'b0, b, d, f, r, 2'b00};
  endfunction

  function automatic logic [31:0] tgt_val(input logic [7:0] b, input logic [4:0] d,
      input logic [2:0] f, input logic [5:0] r);
    return {b, d, f, r, 10'h2A5};
  endfunction

  // row: {write, is_data_port, be[3:0], wdata[31:0], expected[31:0]}
  localparam int NROW = 14;
  localparam logic [69:0] TBL [NROW] = '{
    {1'b1, 1'b0, 4'hF, 32'h8000_0000, 32'h0},
    {1'b0, 1'b0, 4'hF, 32'h0, 32'h8000_0000},                  // R1
    {1'b1, 1'b0, 4'hF, 32'hFF00_0001, 32'h0},
    {1'b0, 1'b0, 4'hF, 32'h0, 32'h8000_0000},                  // R2
    {1'b1, 1'b0, 4'hF, 32'h7F03_2A17, 32'h0},
    {1'b0, 1'b0, 4'hF, 32'h0, 32'h0003_2A14},                  // R2
    {1'b1, 1'b0, 4'hF, mk_addr(1'b1, 8'd3, 5'd2, 3'd5, 6'd4), 32'h0},
    {1'b0, 1'b1, 4'hF, 32'h0, tgt_val(8'd3, 5'd2, 3'd5, 6'd4)}, // R5
    {1'b1, 1'b0, 4'hF, mk_addr(1'b1, 8'h7F, 5'd31, 3'd7, 6'd63), 32'h0},
    {1'b0, 1'b1, 4'hF, 32'h0, ONES},                            // R6
    {1'b1, 1'b0, 4'hF, mk_addr(1'b1, 8'd1, 5'd7, 3'd0, 6'd0), 32'h0},
    {1'b0, 1'b0, 4'hF, 32'h0, mk_addr(1'b1, 8'd1, 5'd7, 3'd0, 6'd0)}, // R1
    {1'b1, 1'b0, 4'hF, 32'h0000_0000, 32'h0},
    {1'b0, 1'b1, 4'hF, 32'h0, ONES}                             // R7
  };

  function automatic string row_req(input int i);
    case (i)
      1, 11:  return "R1";
      3, 5:   return "R2";
      7:      return "R5";
      9:      return "R6";
      default: return "R7";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [15:0] io_port = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic        dn_req_valid;
  logic        dn_req_ready;
  logic        dn_req_write;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_func;
  logic [5:0]  dn_reg;
  logic [31:0] dn_wdata;
  logic [3:0]  dn_be;
  logic        dn_rsp_valid;
  logic [31:0] dn_rsp_data;
  logic        dn_rsp_absent;

  logic        tgt_ready = 1'b1;
  logic        tgt_silent = 1'b0;
  int          req_count = 0;
  logic        cap_write;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_func;
  logic [5:0]  cap_reg;
  logic [31:0] cap_wdata;
  logic [3:0]  cap_be;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dn_req_ready = tgt_ready;

  cfg_port_bridge #(.ADDR_PORT(PA), .DATA_PORT(PD), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_be(io_be), .io_wdata(io_wdata),
    .io_done(io_done), .io_rdata(io_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_write(dn_req_write), .dn_bus(dn_bus), .dn_dev(dn_dev),
    .dn_func(dn_func), .dn_reg(dn_reg), .dn_wdata(dn_wdata), .dn_be(dn_be),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data),
    .dn_rsp_absent(dn_rsp_absent)
  );

  // target model: devices below N_PRESENT answer, others report absent
  always_ff @(posedge clk) begin
    dn_rsp_valid  <= 1'b0;
    dn_rsp_absent <= 1'b0;
    dn_rsp_data   <= 32'h0;
    if (dn_req_valid && dn_req_ready) begin
      req_count <= req_count + 1;
      cap_write <= dn_req_write;
      cap_bus   <= dn_bus;
      cap_dev   <= dn_dev;
      cap_func  <= dn_func;
      cap_reg   <= dn_reg;
      cap_wdata <= dn_wdata;
      cap_be    <= dn_be;
      if (!tgt_silent) begin
        dn_rsp_valid  <= 1'b1;
        dn_rsp_absent <= (int'(dn_dev) >= N_PRESENT);
        dn_rsp_data   <= (int'(dn_dev) >= N_PRESENT) ? 32'h1234_5678
                         : tgt_val(dn_bus, dn_dev, dn_func, dn_reg);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] port, input logic [3:0] be,
      input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_port = port; io_be = be; io_wdata = wd;
    lat = 0;
    rd  = 32'hx;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      lat++;
      if (io_done) begin
        rd = io_rdata;
        break;
      end
    end
    if (!io_done) begin
      total++; bad++;
      $display("FAIL R11 actual=no_done expected=done");
    end
    io_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    int rc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    access(1'b0, PA, 4'hF, 32'h0, rd, lat);
    check("R10 reset value", rd, 32'h0);

    // table walk
    for (int i = 0; i < NROW; i++) begin
      logic [69:0] row;
      row = TBL[i];
      access(row[69], row[68] ? PD : PA, row[67:64], row[63:32], rd, lat);
      if (!row[69]) check(row_req(i), rd, row[31:0]);
    end

    // R3: partial writes keep the register
    access(1'b1, PA, 4'hF, 32'h80AB_CD00, rd, lat);
    access(1'b1, 16'h0CFB, 4'b1000, 32'h0000_0000, rd, lat);
    access(1'b0, PA, 4'hF, 32'h0, rd, lat);
    check("R3 byte write 0xCFB", rd, 32'h80AB_CD00);
    access(1'b1, PA, 4'b0111, 32'h0000_0000, rd, lat);
    access(1'b0, PA, 4'hF, 32'h0, rd, lat);
    check("R3 three-byte write", rd, 32'h80AB_CD00);

    // R11: done lasts one cycle (sampled at next negedge)
    @(negedge clk);
    check("R11 done pulse", {31'b0, io_done}, 32'h0);

    // R4: write forwarding with fields
    access(1'b1, PA, 4'hF, mk_addr(1'b1, 8'd5, 5'd3, 3'd2, 6'd10), rd, lat);
    rc = req_count;
    access(1'b1, PD, 4'h3, 32'hDEAD_BEEF, rd, lat);
    check("R4 one request", 32'(req_count - rc), 32'd1);
    check("R4 write flag", {31'b0, cap_write}, 32'd1);
    check("R4 fields", {cap_bus, 3'b0, cap_dev, 5'b0, cap_func, 2'b0, cap_reg},
          {8'd5, 3'b0, 5'd3, 5'b0, 3'd2, 2'b0, 6'd10});
    check("R4 wdata", cap_wdata, 32'hDEAD_BEEF);
    check("R4 be", {28'b0, cap_be}, 32'h3);

    // R7: disabled write is dropped
    access(1'b1, PA, 4'hF, mk_addr(1'b0, 8'd5, 5'd3, 3'd2, 6'd10), rd, lat);
    rc = req_count;
    access(1'b1, PD, 4'hF, 32'h1111_2222, rd, lat);
    access(1'b0, PD, 4'hF, 32'h0, rd, lat);
    check("R7 disabled read", rd, ONES);
    check("R7 no request", 32'(req_count - rc), 32'd0);

    // R8: held request with delayed ready
    access(1'b1, PA, 4'hF, mk_addr(1'b1, 8'd9, 5'd6, 3'd1, 6'd33), rd, lat);
    rc = req_count;
    @(negedge clk);
    tgt_ready = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        tgt_ready = 1'b1;
      end
      access(1'b0, PD, 4'hF, 32'h0, rd, lat);
    join
    check("R8 delayed ready data", rd, tgt_val(8'd9, 5'd6, 3'd1, 6'd33));
    check("R8 single request", 32'(req_count - rc), 32'd1);

    // R9: silent target times out
    tgt_silent = 1'b1;
    access(1'b0, PD, 4'hF, 32'h0, rd, lat);
    check("R9 timeout data", rd, ONES);
    check("R9 timeout latency", 32'(lat), 32'(TMO + 1));
    tgt_silent = 1'b0;

    // R10: reset mid-run
    access(1'b1, PA, 4'hF, 32'h8012_3400, rd, lat);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(1'b0, PA, 4'hF, 32'h0, rd, lat);
    check("R10 reset clears", rd, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule